// File: doc/BRIEF.md
# Reset Cause Capture Unit

This block sits in the system-control area of a small 8-bit microcontroller. Each cycle it looks at five possible reasons for a system reset: a CPU access into one of two unmapped address gaps, a low-voltage trip with both of its enable bits set, a fault request from the clock generator, a force request written through the debug port, and power-on. When any of these appears, it issues a registered reset request pulse of fixed length. When that pulse ends, it records the cause in a read-only status byte that software can read after the restart.

The status byte has one bit per cause. It is rebuilt at the end of every pulse: every bit is cleared, and then only the causes seen during that reset are set. Causes that arrive while a pulse is running join that same reset and do not extend it. Power-on is the active-low asynchronous input `por_n`. While it is low, the byte holds only the low-voltage bit. The force-reset register can be written only from the debug port. From the CPU bus, that location reads as zero and ignores writes. A forced reset leaves no cause bit set.

Top module: `rst_cause_unit`

## Requirements
- R1: A CPU access with `cpu_strobe` high to any address from 0x0470 to 0x17FF, read or write alike, starts a reset and sets status bit 3.
- R2: A CPU access with `cpu_strobe` high to any address from 0x1860 to 0xBFFF, read or write alike, starts a reset and sets status bit 3.
- R3: Accesses outside both gaps never start a reset. This includes 0x046F, the register page 0x1800 to 0x185F, 0xC000 and up, and 0x0000. An address in a gap with `cpu_strobe` low also never starts a reset.
- R4: A low-voltage reset starts only when `lv_trip`, `lv_rst_en` and `lv_stop_en` are all high in the same cycle, and it sets status bit 1. A trip with either enable low has no effect.
- R5: While `por_n` is low, `reset_req` is low and the status byte reads 0x02 (only the low-voltage bit), whatever it held before.
- R6: `clkgen_fault` high starts a reset and sets status bit 2.
- R7: `dbg_wr` high with `dbg_bit0` = 1 starts a reset that sets no status bit, so the status reads 0x00 afterwards. `dbg_wr` with `dbg_bit0` = 0 has no effect.
- R8: `cpu_rdata` returns the status byte only for a read (`cpu_strobe` high, `cpu_we` low) of address 0x1800. It returns 0x00 in every other case, including any read of the force-reset location 0x1801. CPU writes to 0x1801 or 0x1800 neither start a reset nor change the status.
- R9: `reset_req` goes high on the clock edge that samples a cause and stays high for exactly 4 cycles. The status byte changes only on the edge where `reset_req` falls.
- R10: All causes seen on the starting edge and while the pulse is high, up to and including its final edge, are set together in the status. None of them starts a second pulse.
- R11: Status bits 0 and 7 to 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| cpu_addr | input | 16 | CPU address bus |
| cpu_strobe | input | 1 | CPU access strobe; the address is decoded only while this is high |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_rdata | output | 8 | Read data for the status location, otherwise 0x00 |
| lv_trip | input | 1 | Low-voltage trip |
| lv_rst_en | input | 1 | Low-voltage reset enable |
| lv_stop_en | input | 1 | Low-voltage stop-mode enable |
| clkgen_fault | input | 1 | Reset request from the clock generator |
| dbg_wr | input | 1 | Debug-port write strobe to the force-reset register |
| dbg_bit0 | input | 1 | Bit 0 of the debug write data |
| reset_req | output | 1 | Registered system reset request pulse |
| cause_o | output | 8 | Reset status byte |

## Verification
The properties assume two things about the inputs. First, a cause held high does not need to be seen as a fresh edge: the unit restarts on the first cycle after a pulse in which any cause is still present. Second, `por_n` only changes away from the active clock edge. The stimulus changes inputs shortly after the falling edge. It holds each single-shot cause for one cycle and then idles long enough for the pulse to end, except in the runs that deliberately place a second cause inside a running pulse or hold a trip high across several pulses.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  // status byte bit positions
  localparam int CAUSE_ILL = 3;
  localparam int CAUSE_ICG = 2;
  localparam int CAUSE_LVD = 1;

  typedef struct packed {
    logic ill;
    logic icg;
    logic lvd;
    logic frc;
  } cause_t;

  localparam cause_t NO_CAUSE = '{ill: 1'b0, icg: 1'b0, lvd: 1'b0, frc: 1'b0};

  // power-on value of the status byte: only the low-voltage bit
  localparam logic [DATA_W-1:0] POR_STATUS = DATA_W'(1) << CAUSE_LVD;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] lo,
                                     input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // forced reset contributes no status bit
  function automatic logic [DATA_W-1:0] cause_to_byte(input cause_t c);
    logic [DATA_W-1:0] b;
    b = '0;
    b[CAUSE_ILL] = c.ill;
    b[CAUSE_ICG] = c.icg;
    b[CAUSE_LVD] = c.lvd;
    return b;
  endfunction

  function automatic cause_t cause_or(input cause_t x, input cause_t y);
    return cause_t'(x | y);
  endfunction

  function automatic logic any_cause(input cause_t c);
    return |c;
  endfunction

endpackage

// File: rtl/rcu_addr_screen.sv
module rcu_addr_screen
  import rcu_pkg::*;
#(
  parameter int                        NUM_WIN = 2,
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_LO  = {16'h1860, 16'h0470},
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_HI  = {16'hBFFF, 16'h17FF}
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  output logic              hit
);

  logic [NUM_WIN-1:0] win_hit;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign win_hit[g] = in_window(addr,
                                  WIN_LO[g*ADDR_W +: ADDR_W],
                                  WIN_HI[g*ADDR_W +: ADDR_W]);
  end

  assign hit = strobe && (|win_hit);

endmodule

// File: rtl/rcu_pulse_gen.sv
module rcu_pulse_gen #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic trigger,
  output logic active,
  output logic start,
  output logic finish
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0] remain_q;
  logic             active_q;

  assign start  = trigger && !active_q;
  assign finish = active_q && (remain_q == '0);
  assign active = active_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      active_q <= 1'b0;
      remain_q <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      remain_q <= LAST_CNT;
    end else if (finish) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      remain_q <= remain_q - 1'b1;
    end
  end

endmodule

// File: rtl/rcu_cause_reg.sv
module rcu_cause_reg
  import rcu_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  cause_t            ev,
  input  logic              start,
  input  logic              active,
  input  logic              finish,
  output logic [DATA_W-1:0] status
);

  cause_t            pend_q;
  logic [DATA_W-1:0] status_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pend_q   <= NO_CAUSE;
      status_q <= POR_STATUS;
    end else if (start) begin
      pend_q <= ev;
    end else if (finish) begin
      status_q <= cause_to_byte(cause_or(pend_q, ev));
      pend_q   <= NO_CAUSE;
    end else if (active) begin
      pend_q <= cause_or(pend_q, ev);
    end
  end

  assign status = status_q;

endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
  import rcu_pkg::*;
#(
  parameter int                PULSE_LEN  = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 16'h1800,
  parameter logic [ADDR_W-1:0] FORCE_ADDR = 16'h1801
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_strobe,
  input  logic              cpu_we,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              lv_trip,
  input  logic              lv_rst_en,
  input  logic              lv_stop_en,
  input  logic              clkgen_fault,
  input  logic              dbg_wr,
  input  logic              dbg_bit0,
  output logic              reset_req,
  output logic [DATA_W-1:0] cause_o
);

  logic   ev_ill, ev_lvd, ev_icg, ev_frc, ev_any;
  logic   pulse_start, pulse_end, pulse_on;
  logic   stat_read;
  cause_t ev_now;
  logic [DATA_W-1:0] status;

  rcu_addr_screen u_screen (
    .addr   (cpu_addr),
    .strobe (cpu_strobe),
    .hit    (ev_ill)
  );

  assign ev_lvd = lv_trip && lv_rst_en && lv_stop_en;
  assign ev_icg = clkgen_fault;
  // write-only force register: only the debug path reaches it
  assign ev_frc = dbg_wr && dbg_bit0;

  assign ev_now = '{ill: ev_ill, icg: ev_icg, lvd: ev_lvd, frc: ev_frc};
  assign ev_any = any_cause(ev_now);

  rcu_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .por_n   (por_n),
    .trigger (ev_any),
    .active  (pulse_on),
    .start   (pulse_start),
    .finish  (pulse_end)
  );

  rcu_cause_reg u_cause (
    .clk    (clk),
    .por_n  (por_n),
    .ev     (ev_now),
    .start  (pulse_start),
    .active (pulse_on),
    .finish (pulse_end),
    .status (status)
  );

  // force location (FORCE_ADDR) and everything else reads as zero
  assign stat_read = cpu_strobe && !cpu_we && (cpu_addr == STAT_ADDR);
  assign cpu_rdata = stat_read ? status : '0;

  assign reset_req = pulse_on;
  assign cause_o   = status;

endmodule

// File: rtl/rcu_checker.sv
module rcu_checker
  import rcu_pkg::*;
#(
  parameter int                PULSE_LEN  = 4,
  parameter logic [ADDR_W-1:0] FORCE_ADDR = 16'h1801
) (
  input logic              clk,
  input logic              por_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              lv_trip,
  input logic              lv_rst_en,
  input logic              lv_stop_en,
  input logic              clkgen_fault,
  input logic              dbg_wr,
  input logic              reset_req,
  input logic [DATA_W-1:0] cause_o,
  input logic              ev_ill,
  input logic              ev_any
);

  int hi_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) hi_cnt <= 0;
    else if (reset_req) hi_cnt <= hi_cnt + 1;
    else hi_cnt <= 0;
  end

  // R1 and R2: a gap access while idle raises the request next cycle
  assert_gap_resets_R1: assert property (@(posedge clk) disable iff (!por_n)
    ev_ill && !reset_req |=> reset_req);

  assert_quiet_no_reset_R3: assert property (@(posedge clk) disable iff (!por_n)
    !ev_any && !reset_req |=> !reset_req);

  assert_lv_needs_enables_R4: assert property (@(posedge clk) disable iff (!por_n)
    lv_trip && !(lv_rst_en && lv_stop_en) && !ev_ill && !clkgen_fault && !dbg_wr
      && !reset_req |=> !reset_req);

  assert_clkgen_resets_R6: assert property (@(posedge clk) disable iff (!por_n)
    clkgen_fault && !reset_req |=> reset_req);

  assert_force_reads_zero_R8: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_addr == FORCE_ADDR) |-> (cpu_rdata == '0));

  assert_pulse_length_R9: assert property (@(posedge clk) disable iff (!por_n)
    $fell(reset_req) |-> (hi_cnt == PULSE_LEN));

  assert_pulse_bounded_R9: assert property (@(posedge clk) disable iff (!por_n)
    reset_req |-> (hi_cnt < PULSE_LEN));

  assert_status_moves_at_end_R9: assert property (@(posedge clk) disable iff (!por_n)
    (cause_o != $past(cause_o)) |-> $fell(reset_req));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!por_n)
    (cause_o[0] == 1'b0) && (cause_o[7:4] == 4'h0));

endmodule

bind rst_cause_unit rcu_checker #(
  .PULSE_LEN  (PULSE_LEN),
  .FORCE_ADDR (FORCE_ADDR)
) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .cpu_addr     (cpu_addr),
  .cpu_rdata    (cpu_rdata),
  .lv_trip      (lv_trip),
  .lv_rst_en    (lv_rst_en),
  .lv_stop_en   (lv_stop_en),
  .clkgen_fault (clkgen_fault),
  .dbg_wr       (dbg_wr),
  .reset_req    (reset_req),
  .cause_o      (cause_o),
  .ev_ill       (ev_ill),
  .ev_any       (ev_any)
);

// File: tb/rst_cause_unit_test.sv
module rst_cause_unit_test;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_strobe = 1'b0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        lv_trip = 1'b0, lv_rst_en = 1'b0, lv_stop_en = 1'b0;
  logic        clkgen_fault = 1'b0;
  logic        dbg_wr = 1'b0, dbg_bit0 = 1'b0;
  logic        reset_req;
  logic [7:0]  cause_o;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string phase = "R5";

  // reference model state
  int       m_rem = 0;
  bit       m_p_ill = 0, m_p_icg = 0, m_p_lvd = 0;
  bit [7:0] m_status = 8'h02;

  always #4 clk = ~clk;

  rst_cause_unit uut (
    .clk(clk), .por_n(por_n), .cpu_addr(cpu_addr), .cpu_strobe(cpu_strobe),
    .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .lv_trip(lv_trip),
    .lv_rst_en(lv_rst_en), .lv_stop_en(lv_stop_en), .clkgen_fault(clkgen_fault),
    .dbg_wr(dbg_wr), .dbg_bit0(dbg_bit0), .reset_req(reset_req), .cause_o(cause_o)
  );

  function automatic bit in_gap(input int a);
    if (a >= 'h0470 && a <= 'h17FF) return 1;
    if (a >= 'h1860 && a <= 'hBFFF) return 1;
    return 0;
  endfunction

  // behavioural model, one step per rising edge
  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_rem = 0; m_p_ill = 0; m_p_icg = 0; m_p_lvd = 0; m_status = 8'h02;
    end else begin
      bit e_ill, e_lvd, e_icg, e_frc;
      e_ill = cpu_strobe && in_gap(int'(cpu_addr));
      e_lvd = lv_trip && lv_rst_en && lv_stop_en;
      e_icg = clkgen_fault;
      e_frc = dbg_wr && dbg_bit0;
      if (m_rem == 0) begin
        if (e_ill || e_lvd || e_icg || e_frc) begin
          m_rem = 4; m_p_ill = e_ill; m_p_icg = e_icg; m_p_lvd = e_lvd;
        end
      end else begin
        m_p_ill |= e_ill; m_p_icg |= e_icg; m_p_lvd |= e_lvd;
        m_rem--;
        if (m_rem == 0) begin
          m_status = 8'h00;
          m_status[3] = m_p_ill; m_status[2] = m_p_icg; m_status[1] = m_p_lvd;
          m_p_ill = 0; m_p_icg = 0; m_p_lvd = 0;
        end
      end
    end
  end

  task automatic check8(input string tag, input string what, input logic [7:0] got,
                        input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %02h expected %02h", tag, what, got, exp);
    end
  endtask

  // compare on every falling edge, before the inputs move
  always @(negedge clk) begin
    if (!done) begin
      bit [7:0] exp_rd;
      exp_rd = (cpu_strobe && !cpu_we && cpu_addr == 16'h1800) ? m_status : 8'h00;
      check8(phase, "reset_req", {7'b0, reset_req}, {7'b0, (m_rem > 0)});
      check8(phase, "cause_o", cause_o, m_status);
      check8(phase, "cpu_rdata", cpu_rdata, exp_rd);
      check8("R11", "reserved bits", cause_o & 8'hF1, 8'h00);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic access(input logic [15:0] a, input logic we);
    cpu_addr = a; cpu_we = we; cpu_strobe = 1'b1;
    tick(1);
    cpu_strobe = 1'b0; cpu_we = 1'b0;
    tick(7);
  endtask

  initial begin
    tick(3);
    check8("R5", "status during por", cause_o, 8'h02);
    check8("R5", "req during por", {7'b0, reset_req}, 8'h00);
    por_n = 1'b1;
    tick(3);

    phase = "R1";
    access(16'h0470, 1'b0);
    check8("R1", "status after 0x0470", cause_o, 8'h08);
    access(16'h17FF, 1'b1);
    access(16'h0C00, 1'b0);

    phase = "R3";
    access(16'h1800, 1'b0);  // clear-by-new-reset not needed; legal access only
    phase = "R6";
    clkgen_fault = 1'b1; tick(1); clkgen_fault = 1'b0; tick(7);
    check8("R6", "status after clock fault", cause_o, 8'h04);

    phase = "R2";
    access(16'h1860, 1'b1);
    check8("R2", "status after 0x1860", cause_o, 8'h08);
    access(16'hBFFF, 1'b0);
    access(16'h8000, 1'b1);

    phase = "R3";
    clkgen_fault = 1'b1; tick(1); clkgen_fault = 1'b0; tick(7);
    access(16'h046F, 1'b0);
    access(16'h185F, 1'b1);
    access(16'hC000, 1'b0);
    access(16'h0000, 1'b1);
    access(16'hFFFF, 1'b0);
    cpu_addr = 16'h0800; cpu_strobe = 1'b0; tick(6);
    check8("R3", "status kept after legal accesses", cause_o, 8'h04);

    phase = "R4";
    lv_trip = 1'b1;
    lv_rst_en = 1'b0; lv_stop_en = 1'b0; tick(3);
    lv_rst_en = 1'b1; lv_stop_en = 1'b0; tick(3);
    lv_rst_en = 1'b0; lv_stop_en = 1'b1; tick(3);
    check8("R4", "no reset with an enable low", {7'b0, reset_req}, 8'h00);
    lv_rst_en = 1'b1; tick(1);
    lv_trip = 1'b0; tick(7);
    check8("R4", "status after low-voltage reset", cause_o, 8'h02);
    lv_trip = 1'b1; tick(12);  // held trip: back-to-back pulses
    lv_trip = 1'b0; lv_rst_en = 1'b0; lv_stop_en = 1'b0; tick(8);

    phase = "R7";
    dbg_wr = 1'b1; dbg_bit0 = 1'b0; tick(1); dbg_wr = 1'b0; tick(6);
    check8("R7", "zero force write ignored", cause_o, 8'h02);
    dbg_wr = 1'b1; dbg_bit0 = 1'b1; tick(1); dbg_wr = 1'b0; dbg_bit0 = 1'b0; tick(7);
    check8("R7", "status after forced reset", cause_o, 8'h00);

    phase = "R8";
    clkgen_fault = 1'b1; tick(1); clkgen_fault = 1'b0; tick(7);
    access(16'h1801, 1'b1);
    access(16'h1800, 1'b1);
    cpu_addr = 16'h1801; cpu_we = 1'b0; cpu_strobe = 1'b1; tick(1);
    check8("R8", "force location read", cpu_rdata, 8'h00);
    cpu_addr = 16'h1800; tick(1);
    check8("R8", "status location read", cpu_rdata, 8'h04);
    cpu_strobe = 1'b0; tick(2);

    phase = "R10";
    cpu_addr = 16'h2000; cpu_strobe = 1'b1; clkgen_fault = 1'b1; tick(1);
    cpu_strobe = 1'b0; clkgen_fault = 1'b0; tick(7);
    check8("R10", "simultaneous causes", cause_o, 8'h0C);
    clkgen_fault = 1'b1; tick(1); clkgen_fault = 1'b0; tick(3);
    lv_trip = 1'b1; lv_rst_en = 1'b1; lv_stop_en = 1'b1; tick(1);
    lv_trip = 1'b0; tick(6);
    check8("R10", "late cause merged", cause_o, 8'h06);

    phase = "R9";
    cpu_addr = 16'h0500; cpu_strobe = 1'b1; tick(1); cpu_strobe = 1'b0;
    check8("R9", "req first cycle", {7'b0, reset_req}, 8'h01);
    tick(3);
    check8("R9", "req fourth cycle", {7'b0, reset_req}, 8'h01);
    check8("R9", "status held in pulse", cause_o, 8'h06);
    tick(1);
    check8("R9", "req after four", {7'b0, reset_req}, 8'h00);
    check8("R9", "status at pulse end", cause_o, 8'h08);
    tick(3);

    phase = "R5";
    clkgen_fault = 1'b1; tick(2); clkgen_fault = 1'b0;
    por_n = 1'b0; tick(2);
    check8("R5", "por clears causes", cause_o, 8'h02);
    check8("R5", "por drops req", {7'b0, reset_req}, 8'h00);
    por_n = 1'b1; tick(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired in phase %s got running expected finished", phase);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule